// File: doc/BRIEF.md
# Smart Card Character Receiver with Parity Error Signaling

This block receives characters from a card over a single open-drain I/O line. Each character is a start bit, eight data bits sent least significant bit first, and an even parity bit, followed by a slot in which the receiver may pull the line low. The block detects the falling edge of the start bit and times every bit in elementary time units (ETU, a parameter in clock cycles). It decides each bit by a majority vote of three consecutive samples taken at the bit centre.

When parity fails, the block pulls the line low for one ETU in the slot after the parity bit. This tells the card to resend the character, and the resent character is received as a new one. A bad character still lands in the data output but never raises the ready flag. A good character raises the ready flag, and with it a receive interrupt and a transfer request for a DMA-style engine. That engine's read acknowledge clears the flag. Parity-error and overrun flags stay set until they are cleared by a dedicated strobe. While either is set, the block raises an error interrupt and holds back the transfer request.

Top module: `card_rx`

## Requirements
- R1: After reset the line is released (`io_drive_low`=0), `ready`, `perr` and `ovr` are 0, `rx_data` is 0, and all three request outputs are 0.
- R2: A character is decoded from a start bit (0), eight data bits in LSB-first order and a parity bit. Parity is good when the number of ones across D0..D7 and the parity bit is even. The flags and `rx_data` update exactly 9*ETU + ETU/2 + 5 clock edges after the clock edge at which the start level first appears on `io_line`.
- R3: Each bit is the majority of three consecutive samples, so a one-cycle disturbance inside a bit does not change the decoded value.
- R4: If the start bit is sampled high, the character is abandoned: no flag or data changes and the line is not driven.
- R5: On a parity failure `perr` is set and `ready` is not set, yet the received byte is still loaded into `rx_data`.
- R6: After a parity failure, `io_drive_low` is 1 for exactly ETU cycles, beginning half an ETU after the parity bit ends. It is 0 at every other time.
- R7: A good character sets `ready` and loads `rx_data`. `irq_rx` equals `rie & ready`.
- R8: A pulse on `rd_ack` clears `ready`.
- R9: A good character that completes while `ready` is already 1 sets `ovr`, leaves `rx_data` unchanged and keeps `ready` at 1.
- R10: `irq_err` equals `rie & (perr | ovr)`. `xfer_req` equals `rie & ready & ~perr & ~ovr`.
- R11: `perr` and `ovr` stay set until their clear strobe (`perr_clr`, `ovr_clr`). A new error in the same cycle as its clear strobe leaves the flag set.
- R12: A character resent after an error signal is received as a new character, with no state carried over from the failed attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_line | input | 1 | Level of the shared card I/O line |
| io_drive_low | output | 1 | Enable that pulls the open-drain line low |
| rie | input | 1 | Receive and error interrupt enable |
| rd_ack | input | 1 | Transfer engine has read `rx_data` |
| perr_clr | input | 1 | Clears the parity-error flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_data | output | 8 | Last received byte |
| ready | output | 1 | Good character waiting to be read |
| perr | output | 1 | Parity-error flag |
| ovr | output | 1 | Overrun flag |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |
| xfer_req | output | 1 | Transfer request to the DMA-style engine |

## Verification
The assertions assume the following about the inputs:
- A character on the line keeps each bit level for a whole ETU, apart from isolated single-cycle disturbances.
- A new start edge only arrives after the previous character's error slot has ended.
- `perr_clr` is not pulsed while the block is pulling the line low.
- `rd_ack` does not coincide with the completion of a good character.

The stimulus meets these by building every character from whole-ETU bit periods with at most one one-cycle flip. It also leaves two ETU plus a few cycles of idle line after each parity bit, and pulses acknowledge and clear strobes only while the line is idle between characters.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;

  // Slot numbering inside one character, counted from the start bit.
  localparam int unsigned SLOT_START  = 0;
  localparam int unsigned SLOT_FIRST  = 1;
  localparam int unsigned SLOT_LASTD  = 8;
  localparam int unsigned SLOT_PARITY = 9;
  localparam int unsigned SLOT_ERR    = 10;
  localparam int unsigned SLOT_TAIL   = 11;
  localparam int unsigned SLOT_W      = 4;

  typedef struct packed {
    logic [7:0] value;
    logic       par_ok;
  } rx_char_t;

  // Two-of-three vote over consecutive line samples.
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // Even parity: data plus parity bit carry an even number of ones.
  function automatic logic parity_good(input logic [7:0] d, input logic p);
    return ~(^{d, p});
  endfunction

endpackage

// File: rtl/card_rx_sampler.sv
module card_rx_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_fall,
  output logic bit_val
);
  import card_rx_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  logic                   prev_q;
  logic [2:0]             hist_q;

  assign line_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      hist_q <= 3'b111;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      prev_q <= line_s;
      hist_q <= {hist_q[1:0], line_s};
    end
  end

  assign line_fall = prev_q & ~line_s;
  assign bit_val   = maj3(hist_q);

  initial begin
    if (SYNC_STAGES < 2) $error("card_rx_sampler: SYNC_STAGES must be at least 2");
  end

endmodule

// File: rtl/card_rx_timing.sv
module card_rx_timing #(
  parameter int unsigned ETU = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                line_fall,
  input  logic                                abort,
  output logic                                busy,
  output logic [card_rx_pkg::SLOT_W-1:0]      slot,
  output logic                                sample_stb,
  output logic                                drive_win,
  output logic                                frame_end
);
  import card_rx_pkg::*;

  localparam int unsigned CW = $clog2(ETU);
  localparam logic [CW-1:0] ETU_LAST = CW'(ETU - 1);
  localparam logic [CW-1:0] HALF     = CW'(ETU / 2);
  localparam logic [CW-1:0] SAMP_AT  = CW'(ETU / 2 + 1);
  localparam logic [SLOT_W-1:0] S_PAR  = SLOT_W'(SLOT_PARITY);
  localparam logic [SLOT_W-1:0] S_ERR  = SLOT_W'(SLOT_ERR);
  localparam logic [SLOT_W-1:0] S_TAIL = SLOT_W'(SLOT_TAIL);

  logic [CW-1:0] etu_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      etu_q <= '0;
      slot  <= '0;
    end else if (!busy) begin
      if (line_fall) begin
        busy  <= 1'b1;
        etu_q <= '0;
        slot  <= '0;
      end
    end else if (abort || frame_end) begin
      busy <= 1'b0;
    end else if (etu_q == ETU_LAST) begin
      etu_q <= '0;
      slot  <= slot + 1'b1;
    end else begin
      etu_q <= etu_q + 1'b1;
    end
  end

  assign sample_stb = busy && (etu_q == SAMP_AT) && (slot <= S_PAR);
  assign drive_win  = busy && (((slot == S_ERR) && (etu_q >= HALF)) ||
                               ((slot == S_TAIL) && (etu_q < HALF)));
  assign frame_end  = busy && (slot == S_TAIL) && (etu_q == ETU_LAST);

  initial begin
    if (ETU < 4) $error("card_rx_timing: ETU must be at least 4");
  end

  // R4: an abandoned start returns the receiver to idle on the next edge.
  a_r4_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  // R2: the slot counter never runs past the tail slot of a character.
  a_r2_slot_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot <= S_TAIL));

  // R6: the error window opens only after the counter was in the error slot.
  a_r6_window_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_win) |-> (slot == S_ERR));

endmodule

// File: rtl/card_rx_shift.sv
module card_rx_shift (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sample_stb,
  input  logic [card_rx_pkg::SLOT_W-1:0] slot,
  input  logic                           bit_val,
  output logic                           start_bad,
  output logic                           char_done,
  output card_rx_pkg::rx_char_t          ch
);
  import card_rx_pkg::*;

  localparam logic [SLOT_W-1:0] S_START = SLOT_W'(SLOT_START);
  localparam logic [SLOT_W-1:0] S_FIRST = SLOT_W'(SLOT_FIRST);
  localparam logic [SLOT_W-1:0] S_LASTD = SLOT_W'(SLOT_LASTD);
  localparam logic [SLOT_W-1:0] S_PAR   = SLOT_W'(SLOT_PARITY);

  logic [7:0] sr_q;
  logic       data_slot;

  assign data_slot = (slot >= S_FIRST) && (slot <= S_LASTD);

  // LSB arrives first: shift right so it ends in bit 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sample_stb && data_slot) begin
      sr_q <= {bit_val, sr_q[7:1]};
    end
  end

  assign start_bad = sample_stb && (slot == S_START) && bit_val;
  assign char_done = sample_stb && (slot == S_PAR);
  assign ch.value  = sr_q;
  assign ch.par_ok = parity_good(sr_q, bit_val);

endmodule

// File: rtl/card_rx_flags.sv
module card_rx_flags (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  char_done,
  input  card_rx_pkg::rx_char_t ch,
  input  logic                  rie,
  input  logic                  rd_ack,
  input  logic                  perr_clr,
  input  logic                  ovr_clr,
  output logic [7:0]            rx_data,
  output logic                  ready,
  output logic                  perr,
  output logic                  ovr,
  output logic                  irq_rx,
  output logic                  irq_err,
  output logic                  xfer_req
);
  import card_rx_pkg::*;

  logic good_char, bad_char, ready_after_ack, overrun_evt;

  assign good_char       = char_done && ch.par_ok;
  assign bad_char        = char_done && !ch.par_ok;
  assign ready_after_ack = ready && !rd_ack;
  assign overrun_evt     = good_char && ready_after_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      ready   <= 1'b0;
      perr    <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (good_char && !ready_after_ack) begin
        rx_data <= ch.value;
        ready   <= 1'b1;
      end else begin
        if (bad_char) rx_data <= ch.value;
        if (rd_ack)   ready   <= 1'b0;
      end
      if (bad_char)         perr <= 1'b1;
      else if (perr_clr)    perr <= 1'b0;
      if (overrun_evt)      ovr  <= 1'b1;
      else if (ovr_clr)     ovr  <= 1'b0;
    end
  end

  assign irq_rx   = rie & ready;
  assign irq_err  = rie & (perr | ovr);
  assign xfer_req = rie & ready & ~perr & ~ovr;

  // R5: a bad character never raises ready, but always raises perr.
  a_r5_bad_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_char && !ready) |=> (!ready && perr));

  // R9: overrun keeps the stored byte and the ready flag.
  a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (good_char && ready && !rd_ack) |=> (ovr && ready && $stable(rx_data)));

  // R8: an acknowledge with no new good character empties the buffer.
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rd_ack && !good_char) |=> !ready);

  // R11: the parity-error flag holds until its clear strobe.
  a_r11_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !perr_clr) |=> perr);

  // R11: the overrun flag holds until its clear strobe.
  a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);

endmodule

// File: rtl/card_rx.sv
module card_rx #(
  parameter int unsigned ETU         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_line,
  output logic       io_drive_low,
  input  logic       rie,
  input  logic       rd_ack,
  input  logic       perr_clr,
  input  logic       ovr_clr,
  output logic [7:0] rx_data,
  output logic       ready,
  output logic       perr,
  output logic       ovr,
  output logic       irq_rx,
  output logic       irq_err,
  output logic       xfer_req
);
  import card_rx_pkg::*;

  logic              line_fall, bit_val;
  logic              busy, sample_stb, drive_win, frame_end;
  logic [SLOT_W-1:0] slot;
  logic              start_bad, char_done;
  rx_char_t          ch;
  logic              err_pend_q;

  card_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .line_i(io_line),
    .line_fall(line_fall), .bit_val(bit_val)
  );

  card_rx_timing #(.ETU(ETU)) u_tim (
    .clk(clk), .rst_n(rst_n), .line_fall(line_fall), .abort(start_bad),
    .busy(busy), .slot(slot), .sample_stb(sample_stb),
    .drive_win(drive_win), .frame_end(frame_end)
  );

  card_rx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .slot(slot),
    .bit_val(bit_val), .start_bad(start_bad), .char_done(char_done), .ch(ch)
  );

  card_rx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .ch(ch), .rie(rie),
    .rd_ack(rd_ack), .perr_clr(perr_clr), .ovr_clr(ovr_clr),
    .rx_data(rx_data), .ready(ready), .perr(perr), .ovr(ovr),
    .irq_rx(irq_rx), .irq_err(irq_err), .xfer_req(xfer_req)
  );

  // Error signal request for the current character only (R12: cleared per frame).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       err_pend_q <= 1'b0;
    else if (char_done && !ch.par_ok) err_pend_q <= 1'b1;
    else if (frame_end || !busy)      err_pend_q <= 1'b0;
  end

  assign io_drive_low = drive_win & err_pend_q;

  // R6: the line is only pulled low while a character is in progress.
  a_r6_drive_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    io_drive_low |-> busy);

  // R6: the error signal starts only with the parity-error flag raised.
  a_r6_drive_needs_perr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_drive_low) |-> perr);

  // R12: a fresh character starts with no pending error signal.
  a_r12_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && line_fall) |=> !err_pend_q);

endmodule

// File: tb/sim_card_rx.sv
module sim_card_rx;
  localparam int ETU  = 16;
  localparam int HALF = ETU / 2;
  localparam int UPD  = 9 * ETU + HALF + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_low = 1'b0;
  logic rie = 1'b1, rd_ack = 1'b0, perr_clr = 1'b0, ovr_clr = 1'b0;
  logic io_line, io_drive_low;
  logic [7:0] rx_data;
  logic ready, perr, ovr, irq_rx, irq_err, xfer_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign io_line = !(card_low || io_drive_low);

  card_rx #(.ETU(ETU)) u0 (
    .clk(clk), .rst_n(rst_n), .io_line(io_line), .io_drive_low(io_drive_low),
    .rie(rie), .rd_ack(rd_ack), .perr_clr(perr_clr), .ovr_clr(ovr_clr),
    .rx_data(rx_data), .ready(ready), .perr(perr), .ovr(ovr),
    .irq_rx(irq_rx), .irq_err(irq_err), .xfer_req(xfer_req)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: posedge count, frame bookkeeping, expected flags.
  int         pc = 0;
  int         f_t0 = 0;
  bit         f_on = 1'b0;
  bit         f_bad = 1'b0;
  logic [7:0] f_val = '0;
  logic [7:0] e_data = '0;
  bit         e_rdy = 1'b0, e_per = 1'b0, e_ore = 1'b0, e_drv = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_data = '0; e_rdy = 0; e_per = 0; e_ore = 0; e_drv = 0;
    end else begin
      int rel;
      pc = pc + 1;
      rel = pc - f_t0;
      if (perr_clr) e_per = 0;
      if (ovr_clr)  e_ore = 0;
      if (rd_ack)   e_rdy = 0;
      if (f_on && rel == UPD) begin
        if (f_bad) begin
          e_per  = 1;
          e_data = f_val;
        end else if (e_rdy) begin
          e_ore = 1;
        end else begin
          e_rdy  = 1;
          e_data = f_val;
        end
      end
      e_drv = f_on && f_bad && (rel - 3 >= 10 * ETU + HALF) && (rel - 3 <= 11 * ETU + HALF - 1);
    end
  end

  // Compare every cycle, a quarter period after the rising edge.
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      check_eq("R2 rx_data", rx_data, e_data);
      check_eq("R7 ready", ready, e_rdy);
      check_eq("R5 perr", perr, e_per);
      check_eq("R9 ovr", ovr, e_ore);
      check_eq("R6 io_drive_low", io_drive_low, e_drv);
      check_eq("R7 irq_rx", irq_rx, rie & e_rdy);
      check_eq("R10 irq_err", irq_err, rie & (e_per | e_ore));
      check_eq("R10 xfer_req", xfer_req, rie & e_rdy & ~e_per & ~e_ore);
    end
  end

  bit saw_drive;

  // One character; gslot >= 0 flips that bit for a single cycle mid-bit.
  task automatic send_char(input logic [7:0] v, input bit bad, input int gslot);
    logic [9:0] bits;
    bits = {(^v) ^ bad, v, 1'b0};
    @(negedge clk);
    f_t0 = pc; f_val = v; f_bad = bad; f_on = 1'b1;
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < ETU; c++) begin
        card_low = !bits[k];
        if (k == gslot && c == HALF) card_low = bits[k];
        @(negedge clk);
      end
    end
    card_low  = 1'b0;
    saw_drive = 1'b0;
    for (int c = 0; c < 2 * ETU + 6; c++) begin
      saw_drive |= io_drive_low;
      @(negedge clk);
    end
    check_eq("R6 error signal seen", saw_drive, bad);
  endtask

  task automatic false_start();
    @(negedge clk);
    f_on = 1'b0;
    card_low = 1'b1;
    repeat (3) @(negedge clk);
    card_low = 1'b0;
    saw_drive = 1'b0;
    for (int c = 0; c < 2 * ETU + 6; c++) begin
      saw_drive |= io_drive_low;
      @(negedge clk);
    end
    check_eq("R4 no drive after false start", saw_drive, 1'b0);
  endtask

  task automatic pulse_ack();
    @(negedge clk); rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
  endtask

  task automatic pulse_perr_clr();
    @(negedge clk); perr_clr = 1'b1;
    @(negedge clk); perr_clr = 1'b0;
  endtask

  task automatic pulse_ovr_clr();
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check_eq("R1 drive", io_drive_low, 1'b0);
    check_eq("R1 flags", {ready, perr, ovr}, 3'b000);
    check_eq("R1 data", rx_data, 8'h00);
    check_eq("R1 requests", {irq_rx, irq_err, xfer_req}, 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R7: good character
    send_char(8'hA5, 1'b0, -1);
    check_eq("R2 byte", rx_data, 8'hA5);
    check_eq("R7 xfer_req", xfer_req, 1'b1);

    // R8: acknowledge
    pulse_ack();
    check_eq("R8 ready cleared", ready, 1'b0);

    // R5 R6 R10: parity failure
    send_char(8'h3C, 1'b1, -1);
    check_eq("R5 byte kept", rx_data, 8'h3C);
    check_eq("R5 ready", ready, 1'b0);
    check_eq("R10 irq_err", irq_err, 1'b1);

    // R12 R11 R10: resend while perr still set
    send_char(8'h3C, 1'b0, -1);
    check_eq("R12 resend ready", ready, 1'b1);
    check_eq("R11 perr sticky", perr, 1'b1);
    check_eq("R10 xfer withheld", xfer_req, 1'b0);
    pulse_perr_clr();
    check_eq("R11 perr cleared", perr, 1'b0);
    check_eq("R10 xfer released", xfer_req, 1'b1);

    // R9: overrun
    send_char(8'h5A, 1'b0, -1);
    check_eq("R9 ovr", ovr, 1'b1);
    check_eq("R9 data held", rx_data, 8'h3C);
    pulse_ovr_clr();
    pulse_ack();
    check_eq("R11 ovr cleared", ovr, 1'b0);

    // R3: one-cycle disturbances
    send_char(8'h81, 1'b0, 1);
    check_eq("R3 glitch D0", rx_data, 8'h81);
    pulse_ack();
    send_char(8'h81, 1'b0, 9);
    check_eq("R3 glitch parity", {rx_data, perr}, {8'h81, 1'b0});
    pulse_ack();

    // R4: false start then a normal character
    false_start();
    check_eq("R4 no flags", {ready, perr, ovr}, 3'b000);
    check_eq("R4 data unchanged", rx_data, 8'h81);
    send_char(8'h7E, 1'b0, -1);
    check_eq("R4 recovery", rx_data, 8'h7E);
    pulse_ack();

    // R7: interrupts disabled
    @(negedge clk); rie = 1'b0;
    send_char(8'h12, 1'b0, -1);
    check_eq("R7 irq_rx masked", irq_rx, 1'b0);
    check_eq("R7 ready set", ready, 1'b1);
    pulse_ack();
    send_char(8'hC3, 1'b1, -1);
    check_eq("R10 irq_err masked", irq_err, 1'b0);
    pulse_perr_clr();
    @(negedge clk); rie = 1'b1;

    // R2: a spread of byte values
    for (int i = 0; i < 4; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 11) ^ 8'hF0;
      send_char(v, 1'b0, -1);
      check_eq("R2 sweep", rx_data, v);
      pulse_ack();
    end

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule